// File: doc/BRIEF.md
# Serial Register Access Port

This block is the debug and load port of a small stack-based processor core. An external host moves one byte at a time in and out of the core through an 8-bit shift register, using a single serial data line in each direction. A 3-bit select field names the target inside the core: the program counter, the stack pointer, the stack, the program-memory byte at the current program counter, or an execute-in-place opcode path. Two strobes act on that target. `load` copies the shift register into the target. `dump` copies the target's value back into the shift register so that the host can clock it out.

On the core side the port gives one registered write strobe per target and a shared write-data byte. It also gives a one-hot read request that is combinational during a dump, and it takes one read-data byte from each readable target. A load into the execute target does not store anything. It sends the byte to the core as an opcode to run at once, as a single-cycle pulse. A load into the stack target is a push. The core performs the instructions and owns the storage. The port only moves bytes and produces the strobes.

Top module: `sap_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sout` is 0 and every write strobe (`wr_pc`, `wr_sp`, `exec_valid`, `stk_push`, `wr_mem`) is 0.
- R2: In a cycle with neither `load` nor `dump` high, the shift register moves one place toward its MSB on the rising edge. `sin` enters at bit 0, and `sout` always shows bit 7. A byte shifted in MSB first therefore comes out MSB first.
- R3: The select encodings are 0 = program counter, 1 = stack pointer, 2 = execute, 3 = stack, 4 = program-memory byte, and 5 to 7 are unmapped. When `load` rises while `dump` is low, exactly one write strobe goes high for one cycle, in the next cycle: `wr_pc` for 0, `wr_sp` for 1, `wr_mem` for 4. In that cycle `core_wdata` holds the shift-register byte.
- R4: A load with select 2 produces a single-cycle `exec_valid` pulse with the byte on `core_wdata`. No other strobe fires, so program memory is not written.
- R5: A load with select 3 produces a single-cycle `stk_push`. A dump with select 3 raises only the stack read request and does not push.
- R6: In a cycle with `dump` high, `rd_stb` is one-hot at the selected target's bit (bit index = encoding), or zero for an unmapped select. The shift register takes the target's read data on the edge. In every other cycle `rd_stb` is zero.
- R7: If `load` and `dump` are high in the same cycle, the dump is carried out and no write strobe follows.
- R8: A write fires once for each rising edge of `load`. Holding `load` high for several cycles gives one strobe.
- R9: While `load` is high and `dump` is low, the shift register does not shift, so `sout` is unchanged on the following cycle.
- R10: A load with an unmapped select (5 to 7) produces no strobe. A dump with an unmapped select, or with the execute select, puts 0x00 into the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Target select (see R3) |
| load | input | 1 | Copy shift register into target on its rising edge |
| dump | input | 1 | Copy target read data into shift register |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out (shift-register MSB) |
| pc_rdata | input | 8 | Program counter read value |
| sp_rdata | input | 8 | Stack pointer read value |
| stk_top | input | 8 | Top-of-stack read value |
| mem_rdata | input | 8 | Program-memory byte at the program counter |
| rd_stb | output | 5 | One-hot read request during a dump, bit = encoding |
| wr_pc | output | 1 | Program counter write strobe |
| wr_sp | output | 1 | Stack pointer write strobe |
| exec_valid | output | 1 | Execute-in-place opcode pulse |
| stk_push | output | 1 | Stack push strobe |
| wr_mem | output | 1 | Program-memory write strobe |
| core_wdata | output | 8 | Byte for the strobed target |

## Verification
The properties assume that the select field is stable in any cycle where `load` or `dump` is high. They also assume that the core returns its read data combinationally in the cycle of the request, and that no sequence needs `load` to produce back-to-back writes without first falling. The stimulus changes `sel`, `load`, `dump` and `sin` only just after a rising edge. It drops `load` for at least one cycle between writes. Its core stubs answer reads from plain bench state, so both the dump path and the stubs see the values that were present before the edge.

// File: rtl/sap_pkg.sv
package sap_pkg;
   localparam int SEL_W = 3;
   localparam int N_TGT = 5;

   typedef enum logic [SEL_W-1:0] {
      SEL_PC    = 3'd0,
      SEL_SP    = 3'd1,
      SEL_EXEC  = 3'd2,
      SEL_STACK = 3'd3,
      SEL_MEM   = 3'd4
   } sap_sel_e;
endpackage

// File: rtl/sap_decode.sv
module sap_decode
   import sap_pkg::*;
#(
   parameter int NT = N_TGT
) (
   input  logic [SEL_W-1:0] sel,
   output logic [NT-1:0]    hit
);
   initial begin
      if (NT > (1 << SEL_W)) $error("sap_decode: more targets than select codes");
   end

   for (genvar i = 0; i < NT; i++) begin : g_hit
      assign hit[i] = (sel == SEL_W'(i));
   end
endmodule

// File: rtl/sap_shifter.sv
module sap_shifter #(
   parameter int DW        = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic          hold,
   input  logic [DW-1:0] cap_data,
   input  logic          sin,
   output logic          sout,
   output logic [DW-1:0] q
);
   initial begin
      if (DW < 2) $error("sap_shifter: DW must be at least 2");
   end

   logic [DW-1:0] shifted;

   if (MSB_FIRST) begin : g_msb
      assign shifted = {q[DW-2:0], sin};
      assign sout    = q[DW-1];
   end else begin : g_lsb
      assign shifted = {sin, q[DW-1:1]};
      assign sout    = q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (cap)  q <= cap_data;
      else if (!hold) q <= shifted;
   end
endmodule

// File: rtl/sap_strobe.sv
module sap_strobe #(
   parameter int DW = 8,
   parameter int NT = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          dump,
   input  logic [NT-1:0] hit,
   input  logic [DW-1:0] din,
   output logic [NT-1:0] wr,
   output logic [DW-1:0] wdata
);
   logic load_q;
   logic fire;

   assign fire = load & ~load_q & ~dump;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         wr     <= '0;
         wdata  <= '0;
      end else begin
         load_q <= load;
         wr     <= fire ? hit : '0;
         if (fire) wdata <= din;
      end
   end
endmodule

// File: rtl/sap_port.sv
module sap_port
   import sap_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             load,
   input  logic             dump,
   input  logic             sin,
   output logic             sout,
   input  logic [DW-1:0]    pc_rdata,
   input  logic [DW-1:0]    sp_rdata,
   input  logic [DW-1:0]    stk_top,
   input  logic [DW-1:0]    mem_rdata,
   output logic [N_TGT-1:0] rd_stb,
   output logic             wr_pc,
   output logic             wr_sp,
   output logic             exec_valid,
   output logic             stk_push,
   output logic             wr_mem,
   output logic [DW-1:0]    core_wdata
);
   initial begin
      if (DW != 8) $error("sap_port: core path is byte wide");
   end

   logic [N_TGT-1:0] hit;
   logic [N_TGT-1:0] wr;
   logic [DW-1:0]    rd_bus [N_TGT];
   logic [DW-1:0]    rd_val;
   logic [DW-1:0]    sr_q;

   sap_decode #(.NT(N_TGT)) u_dec (
      .sel (sel),
      .hit (hit)
   );

   assign rd_bus[SEL_PC]    = pc_rdata;
   assign rd_bus[SEL_SP]    = sp_rdata;
   assign rd_bus[SEL_EXEC]  = '0;
   assign rd_bus[SEL_STACK] = stk_top;
   assign rd_bus[SEL_MEM]   = mem_rdata;

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N_TGT; i++) begin
         if (hit[i]) rd_val = rd_val | rd_bus[i];
      end
   end

   assign rd_stb = dump ? hit : '0;

   sap_shifter #(.DW(DW), .MSB_FIRST(MSB_FIRST)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (dump),
      .hold     (load),
      .cap_data (rd_val),
      .sin      (sin),
      .sout     (sout),
      .q        (sr_q)
   );

   sap_strobe #(.DW(DW), .NT(N_TGT)) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .dump  (dump),
      .hit   (hit),
      .din   (sr_q),
      .wr    (wr),
      .wdata (core_wdata)
   );

   assign wr_pc      = wr[SEL_PC];
   assign wr_sp      = wr[SEL_SP];
   assign exec_valid = wr[SEL_EXEC];
   assign stk_push   = wr[SEL_STACK];
   assign wr_mem     = wr[SEL_MEM];
endmodule

// File: rtl/sap_checker.sv
module sap_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] sel,
   input logic       load,
   input logic       dump,
   input logic       sout,
   input logic [4:0] rd_stb,
   input logic       wr_pc,
   input logic       wr_sp,
   input logic       exec_valid,
   input logic       stk_push,
   input logic       wr_mem
);
   logic [4:0] wrv;
   assign wrv = {wr_mem, stk_push, exec_valid, wr_sp, wr_pc};

   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wrv));

   a_r4_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |=> !exec_valid);

   a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wrv != 5'd0) |=> (wrv == 5'd0));

   a_r7_dump_wins: assert property (@(posedge clk) disable iff (!rst_n)
      dump |=> (wrv == 5'd0));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !dump) |=> $stable(sout));

   a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel > 3'd4) |=> (wrv == 5'd0));

   a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dump |-> (rd_stb == 5'd0));

   a_r6_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      dump |-> $onehot0(rd_stb));
endmodule

bind sap_port sap_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel        (sel),
   .load       (load),
   .dump       (dump),
   .sout       (sout),
   .rd_stb     (rd_stb),
   .wr_pc      (wr_pc),
   .wr_sp      (wr_sp),
   .exec_valid (exec_valid),
   .stk_push   (stk_push),
   .wr_mem     (wr_mem)
);

// File: tb/sim_sap_port.sv
module sim_sap_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       load = 1'b0, dump = 1'b0, sin = 1'b0;
   logic       sout;
   logic [7:0] pc_rdata, sp_rdata, stk_top, mem_rdata, core_wdata;
   logic [4:0] rd_stb;
   logic       wr_pc, wr_sp, exec_valid, stk_push, wr_mem;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sap_port u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .load(load), .dump(dump),
      .sin(sin), .sout(sout), .pc_rdata(pc_rdata), .sp_rdata(sp_rdata),
      .stk_top(stk_top), .mem_rdata(mem_rdata), .rd_stb(rd_stb),
      .wr_pc(wr_pc), .wr_sp(wr_sp), .exec_valid(exec_valid),
      .stk_push(stk_push), .wr_mem(wr_mem), .core_wdata(core_wdata)
   );

   // core stubs
   logic [7:0] pc, sp, last_exec;
   logic [7:0] mem [32];
   logic [7:0] stk [32];
   int n_exec, n_writes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= 8'h00; sp <= 8'h00; last_exec <= 8'h00;
         n_exec <= 0; n_writes <= 0;
         for (int i = 0; i < 32; i++) begin
            mem[i] <= 8'hFF;
            stk[i] <= 8'h00;
         end
      end else begin
         if (wr_pc || wr_sp || exec_valid || stk_push || wr_mem) n_writes <= n_writes + 1;
         if (wr_pc) pc <= core_wdata;
         if (wr_sp) sp <= core_wdata;
         if (exec_valid) begin
            last_exec <= core_wdata;
            n_exec <= n_exec + 1;
         end
         if (stk_push) begin
            stk[sp[4:0]] <= core_wdata;
            sp <= sp + 8'd1;
         end
         if (wr_mem) begin
            mem[pc[4:0]] <= core_wdata;
            pc <= pc + 8'd1;
         end
      end
   end

   assign pc_rdata  = pc;
   assign sp_rdata  = sp;
   assign stk_top   = (sp == 8'd0) ? 8'h00 : stk[sp[4:0] - 5'd1];
   assign mem_rdata = mem[pc[4:0]];

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   // behavioural reference, evaluated between edges
   int   m_sr = 0;
   bit   m_prev = 1'b0;
   int   m_wr = 0;
   int   m_wdata = 0;
   bit   m_live = 1'b0;

   function automatic int read_of(input int s);
      case (s)
         0: return int'(pc);
         1: return int'(sp);
         3: return int'(stk_top);
         4: return int'(mem_rdata);
         default: return 0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (m_live) begin
         chk(sout == m_sr[7], "R2 sout vs model", int'(sout), m_sr[7]);
         chk({wr_mem, stk_push, exec_valid, wr_sp, wr_pc} == 5'(m_wr),
             "R3 strobes vs model", int'({wr_mem, stk_push, exec_valid, wr_sp, wr_pc}), m_wr);
         if (m_wr != 0) chk(core_wdata == 8'(m_wdata), "R3 wdata vs model", int'(core_wdata), m_wdata);
      end
      if (rst_n) begin
         chk(rd_stb == ((dump && sel < 3'd5) ? 5'(1 << sel) : 5'd0), "R6 rd_stb",
             int'(rd_stb), (dump && sel < 3'd5) ? (1 << sel) : 0);
      end
      if (!rst_n) begin
         m_sr = 0; m_prev = 0; m_wr = 0; m_wdata = 0;
      end else begin
         if (dump) begin
            m_sr = read_of(int'(sel));
            m_wr = 0;
         end else if (load) begin
            if (!m_prev && sel < 3'd5) begin
               m_wr = 1 << sel;
               m_wdata = m_sr;
            end else m_wr = 0;
         end else begin
            m_sr = ((m_sr << 1) | int'(sin)) & 8'hFF;
            m_wr = 0;
         end
         m_prev = load;
      end
      m_live = 1'b1;
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic shift_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sin = b[i]; load = 0; dump = 0;
         step();
      end
      sin = 0;
   endtask

   task automatic do_load(input logic [2:0] s, input int n);
      sel = s; load = 1;
      repeat (n) step();
      load = 0;
      step();
   endtask

   task automatic read_reg(input logic [2:0] s, output logic [7:0] v);
      sel = s; dump = 1;
      step();
      dump = 0; sin = 0;
      for (int i = 7; i >= 0; i--) begin
         v[i] = sout;
         step();
      end
   endtask

   logic [7:0] v;
   int w0;

   initial begin
      #1;
      chk(sout == 1'b0, "R1 sout in reset", int'(sout), 0);
      chk({wr_mem, stk_push, exec_valid, wr_sp, wr_pc} == 5'd0, "R1 strobes in reset",
          int'({wr_mem, stk_push, exec_valid, wr_sp, wr_pc}), 0);
      repeat (3) step();
      rst_n = 1;
      step();
      chk(sout == 1'b0, "R1 sout after reset", int'(sout), 0);

      read_reg(3'd4, v);
      chk(v == 8'hFF, "R6 dump mem after reset", v, 8'hFF);

      shift_byte(8'hA5); do_load(3'd0, 1);
      chk(pc == 8'hA5, "R3 pc written", pc, 8'hA5);
      read_reg(3'd0, v);
      chk(v == 8'hA5, "R2 pc shifted out MSB first", v, 8'hA5);

      shift_byte(8'h00); do_load(3'd0, 1);
      shift_byte(8'h3C); do_load(3'd4, 1);
      chk(mem[0] == 8'h3C && pc == 8'd1, "R3 mem write", mem[0], 8'h3C);
      shift_byte(8'h00); do_load(3'd0, 1);
      read_reg(3'd4, v);
      chk(v == 8'h3C, "R6 mem read back", v, 8'h3C);

      w0 = n_writes;
      shift_byte(8'h77); do_load(3'd2, 1);
      chk(n_exec == 1 && last_exec == 8'h77, "R4 exec pulse", last_exec, 8'h77);
      chk(n_writes == w0 + 1 && mem[0] == 8'h3C, "R4 single strobe, no mem write", n_writes - w0, 1);
      read_reg(3'd2, v);
      chk(v == 8'h00, "R10 exec dumps zero", v, 0);

      shift_byte(8'h12); do_load(3'd3, 1);
      shift_byte(8'h34); do_load(3'd3, 1);
      read_reg(3'd3, v);
      chk(v == 8'h34, "R5 top of stack", v, 8'h34);
      read_reg(3'd3, v);
      chk(v == 8'h34, "R5 dump does not pop", v, 8'h34);
      read_reg(3'd1, v);
      chk(v == 8'd2, "R5 sp after pushes", v, 2);

      w0 = n_writes;
      shift_byte(8'h55);
      sel = 3'd3; load = 1; dump = 1;
      step();
      dump = 0;
      step(); step();
      load = 0;
      step();
      chk(n_writes == w0 && sp == 8'd2, "R7 dump beats load", n_writes - w0, 0);

      w0 = n_writes;
      shift_byte(8'h99); do_load(3'd3, 4);
      chk(n_writes == w0 + 1 && sp == 8'd3, "R8 held load writes once", n_writes - w0, 1);

      w0 = n_writes;
      shift_byte(8'h80);
      sel = 3'd6; load = 1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk(sout == 1'b1, "R9 sout holds during load", int'(sout), 1);
      end
      load = 0;
      step();
      chk(n_writes == w0, "R10 unmapped load no strobe", n_writes - w0, 0);
      read_reg(3'd7, v);
      chk(v == 8'h00, "R10 unmapped dump zero", v, 0);

      repeat (4) step();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule